// File: doc/BRIEF.md
# Clock Group Stop and Power-Down Gate

This block sits between the synthesized clocks of a system clock generator and its output pads. It receives eight free-running group clocks and three asynchronous active-low controls. It passes each group clock through a glitch-free gate. The CPU-stop control halts the CPU and 66 MHz groups. The PCI-stop control halts the stoppable PCI group. The power-down control halts every group and drops the enables for the crystal oscillator and the VCOs.

Stop and start timing is counted in rising edges of the free-running PCI clock, and all control decisions are taken in that clock domain. A gated output only changes state while its source clock is low. As a result, a stopped output rests low, and the first and last pulses of any burst have full width. After reset, and again after power down is released, a counter running on the reference clock models the oscillator and PLL restart delay. All outputs stay low until that counter expires.

Top module: `clk_stop_ctrl`

## Requirements
- R1: While `rst_n` is low, all eight bits of `clk_out`, `osc_en` and `vco_en` are low. Group bit positions in `clk_in`/`clk_out`: 0 CPU, 1 66 MHz, 2 stoppable PCI, 3 free-running PCI, 4 half-rate memory reference, 5 IO interrupt, 6 reference, 7 48 MHz.
- R2: After reset release, or after `pwrdn_n` rises, no output rises until SETTLE_CYC reference-clock periods (bit 6) have passed. The free-running PCI output starts no later than SETTLE_CYC+3 reference periods plus 100 ns after release. Every unstopped group then runs.
- R3: While `pwrdn_n` is low, all of `clk_out` stays low. After `pwrdn_n` falls, the free-running PCI output gives at most two further rising edges.
- R4: `osc_en` and `vco_en` fall within four reference-clock rising edges after `pwrdn_n` is held low. `vco_en` is only high while `osc_en` is high. On restart, `osc_en` rises at least one reference period before `vco_en`.
- R5: While `cpu_stop_n` is low, the CPU and 66 MHz groups rest low. The memory reference, IO interrupt, reference, 48 MHz and both PCI groups keep running.
- R6: While `pci_stop_n` is low, the stoppable PCI group rests low. The free-running PCI group and all other groups keep running.
- R7: Suppose a stop input changes during the high phase of the free-running PCI clock, and P is the next rising edge of that clock. When stopping, the last rising edge of the stopped groups coincides with P. When releasing, the first rising edge comes at P plus one CPU period for the CPU group, P plus one 66 MHz period for the 66 MHz group, and the PCI rising edge after P for the stoppable PCI group.
- R8: Every high pulse on every gated output lasts exactly half of its source clock period.
- R9: Toggling a stop input during power down has no visible effect. A stop input held low through a power-up keeps its groups stopped while the rest start, and its groups start once it is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_in | input | 8 | Free-running group clocks, bit map in R1 |
| cpu_stop_n | input | 1 | Asynchronous active-low stop for CPU and 66 MHz groups |
| pci_stop_n | input | 1 | Asynchronous active-low stop for the stoppable PCI group |
| pwrdn_n | input | 1 | Asynchronous active-low power-down request |
| clk_out | output | 8 | Gated group clocks, same bit map |
| osc_en | output | 1 | Crystal oscillator enable |
| vco_en | output | 1 | PLL VCO enable |

## Verification
The bench changes each stop input one nanosecond after a PCI rising edge and timestamps the last and first gated edges. With one synchronizer stage too many, the edge would come one PCI period late. With the gating flop on the wrong clock edge, pulses would appear truncated or the edge would land half a period off. Every falling edge is checked against the expected half period of its source clock, so a gate that switches while its clock is high shows up as a runt pulse. The bench toggles the stop inputs during power down, and it releases power down while CPU stop is held. A design that lets the stops bypass the power state, or that restarts all groups unconditionally, would show edges on groups that must stay quiet. The power-up window is bounded on both sides, so a counter that is short, skipped or never expires is caught.

// File: rtl/clkstop_pkg.sv
`timescale 1ns/1ps
package clkstop_pkg;
  localparam int NUM_GRP = 8;
  localparam int G_CPU  = 0;
  localparam int G_M66  = 1;
  localparam int G_PCI  = 2;
  localparam int G_PCIF = 3;
  localparam int G_MEM  = 4;
  localparam int G_APIC = 5;
  localparam int G_REF  = 6;
  localparam int G_USB  = 7;

  localparam logic [NUM_GRP-1:0] CPU_STOP_SET = 8'b0000_0011;
  localparam logic [NUM_GRP-1:0] PCI_STOP_SET = 8'b0000_0100;
  localparam logic [NUM_GRP-1:0] ASYNC_SET    = 8'b1100_0000;

  function automatic logic [NUM_GRP-1:0] grp_run(input logic cpu_go,
                                                 input logic pci_go,
                                                 input logic pwr_go);
    logic [NUM_GRP-1:0] r;
    for (int i = 0; i < NUM_GRP; i++) begin
      r[i] = pwr_go & (~CPU_STOP_SET[i] | cpu_go) & (~PCI_STOP_SET[i] | pci_go);
    end
    return r;
  endfunction
endpackage

// File: rtl/clkstop_sync.sv
`timescale 1ns/1ps
module clkstop_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= STAGES'({sh, d});
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/clkstop_settle.sv
`timescale 1ns/1ps
module clkstop_settle #(
  parameter int SETTLE_CYC  = 42955,
  parameter int SYNC_STAGES = 2
) (
  input  logic ref_clk,
  input  logic rst_n,
  input  logic pwrdn_n,
  output logic osc_en,
  output logic vco_en,
  output logic ready
);
  localparam int CW = $clog2(SETTLE_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(SETTLE_CYC);

  logic          pwr_req;
  logic [CW-1:0] cnt;
  logic          osc_q, vco_q, rdy_q;

  clkstop_sync #(.STAGES(SYNC_STAGES)) u_pd_sync (
    .clk(ref_clk), .rst_n(rst_n), .d(pwrdn_n), .q(pwr_req)
  );

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      osc_q <= 1'b0;
      vco_q <= 1'b0;
      rdy_q <= 1'b0;
    end else begin
      osc_q <= pwr_req;
      vco_q <= osc_q & pwr_req;
      if (!pwr_req)         cnt <= '0;
      else if (cnt != LAST) cnt <= cnt + 1'b1;
      rdy_q <= pwr_req && (cnt == LAST);
    end
  end

  assign osc_en = osc_q;
  assign vco_en = vco_q;
  assign ready  = rdy_q;
endmodule

// File: rtl/clkstop_req.sv
`timescale 1ns/1ps
module clkstop_req
  import clkstop_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               pci_clk,
  input  logic               rst_n,
  input  logic               cpu_stop_n,
  input  logic               pci_stop_n,
  input  logic               pwrdn_n,
  input  logic               ready_ref,
  output logic [NUM_GRP-1:0] run
);
  logic cs_meta, ps_meta, pd_meta;
  logic cpu_go, pci_go, pwr_go;
  logic rdy_pci;

  // first stage on the falling edge so the decision lands on the next rising edge
  always_ff @(negedge pci_clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_meta <= 1'b0;
      ps_meta <= 1'b0;
      pd_meta <= 1'b0;
    end else begin
      cs_meta <= cpu_stop_n;
      ps_meta <= pci_stop_n;
      pd_meta <= pwrdn_n;
    end
  end

  always_ff @(posedge pci_clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_go <= 1'b0;
      pci_go <= 1'b0;
      pwr_go <= 1'b0;
    end else begin
      cpu_go <= cs_meta;
      pci_go <= ps_meta;
      pwr_go <= pd_meta;
    end
  end

  clkstop_sync #(.STAGES(SYNC_STAGES)) u_rdy_sync (
    .clk(pci_clk), .rst_n(rst_n), .d(ready_ref), .q(rdy_pci)
  );

  assign run = grp_run(cpu_go, pci_go, pwr_go & rdy_pci);
endmodule

// File: rtl/clkstop_gate.sv
`timescale 1ns/1ps
module clkstop_gate #(
  parameter int STAGES = 1
) (
  input  logic clk_src,
  input  logic rst_n,
  input  logic run,
  output logic clk_gated
);
  logic [STAGES-1:0] en_sh;

  // enable only moves while the source clock is low
  always_ff @(negedge clk_src or negedge rst_n) begin
    if (!rst_n) en_sh <= '0;
    else        en_sh <= STAGES'({en_sh, run});
  end

  assign clk_gated = clk_src & en_sh[STAGES-1];
endmodule

// File: rtl/clk_stop_ctrl.sv
`timescale 1ns/1ps
module clk_stop_ctrl
  import clkstop_pkg::*;
#(
  parameter int SETTLE_CYC        = 42955,
  parameter int SYNC_STAGES       = 2,
  parameter int ASYNC_GATE_STAGES = 2
) (
  input  logic               rst_n,
  input  logic [NUM_GRP-1:0] clk_in,
  input  logic               cpu_stop_n,
  input  logic               pci_stop_n,
  input  logic               pwrdn_n,
  output logic [NUM_GRP-1:0] clk_out,
  output logic               osc_en,
  output logic               vco_en
);
  logic               ready_ref;
  logic [NUM_GRP-1:0] run;

  clkstop_settle #(.SETTLE_CYC(SETTLE_CYC), .SYNC_STAGES(SYNC_STAGES)) u_settle (
    .ref_clk(clk_in[G_REF]), .rst_n(rst_n), .pwrdn_n(pwrdn_n),
    .osc_en(osc_en), .vco_en(vco_en), .ready(ready_ref)
  );

  clkstop_req #(.SYNC_STAGES(SYNC_STAGES)) u_req (
    .pci_clk(clk_in[G_PCIF]), .rst_n(rst_n), .cpu_stop_n(cpu_stop_n),
    .pci_stop_n(pci_stop_n), .pwrdn_n(pwrdn_n), .ready_ref(ready_ref), .run(run)
  );

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    localparam int ST = ASYNC_SET[g] ? ASYNC_GATE_STAGES : 1;
    clkstop_gate #(.STAGES(ST)) u_gate (
      .clk_src(clk_in[g]), .rst_n(rst_n), .run(run[g]), .clk_gated(clk_out[g])
    );
  end
endmodule

// File: rtl/clk_stop_ctrl_chk.sv
`timescale 1ns/1ps
module clk_stop_ctrl_chk
  import clkstop_pkg::*;
#(
  parameter int SETTLE_CYC = 42955
) (
  input logic               rst_n,
  input logic [NUM_GRP-1:0] clk_in,
  input logic               cpu_stop_n,
  input logic               pci_stop_n,
  input logic               pwrdn_n,
  input logic [NUM_GRP-1:0] clk_out,
  input logic               osc_en,
  input logic               vco_en
);
  localparam int BW = $clog2(SETTLE_CYC + 1);
  localparam logic [BW-1:0] BLAST = BW'(SETTLE_CYC);

  logic [2:0]    cs_cnt, ps_cnt, pd_cnt, pdr_cnt;
  logic [BW-1:0] boot_cnt;

  always_ff @(posedge clk_in[G_PCIF] or negedge rst_n) begin
    if (!rst_n) begin
      cs_cnt <= '0; ps_cnt <= '0; pd_cnt <= '0;
    end else begin
      cs_cnt <= cpu_stop_n ? 3'd0 : (cs_cnt == 3'd7 ? cs_cnt : cs_cnt + 3'd1);
      ps_cnt <= pci_stop_n ? 3'd0 : (ps_cnt == 3'd7 ? ps_cnt : ps_cnt + 3'd1);
      pd_cnt <= pwrdn_n    ? 3'd0 : (pd_cnt == 3'd7 ? pd_cnt : pd_cnt + 3'd1);
    end
  end

  always_ff @(posedge clk_in[G_REF] or negedge rst_n) begin
    if (!rst_n) begin
      pdr_cnt  <= '0;
      boot_cnt <= '0;
    end else begin
      pdr_cnt  <= pwrdn_n ? 3'd0 : (pdr_cnt == 3'd7 ? pdr_cnt : pdr_cnt + 3'd1);
      if (boot_cnt != BLAST) boot_cnt <= boot_cnt + 1'b1;
    end
  end

  // R4
  osc_off_chk: assert property (@(posedge clk_in[G_REF]) disable iff (!rst_n)
    (pdr_cnt >= 3'd4) |-> (!osc_en && !vco_en));
  // R4
  vco_osc_chk: assert property (@(posedge clk_in[G_REF]) disable iff (!rst_n)
    vco_en |-> osc_en);
  // R5
  cpu_halt_chk: assert property (@(negedge clk_in[G_CPU]) disable iff (!rst_n)
    (cs_cnt >= 3'd3) |-> !clk_out[G_CPU]);
  // R5
  m66_halt_chk: assert property (@(negedge clk_in[G_M66]) disable iff (!rst_n)
    (cs_cnt >= 3'd3) |-> !clk_out[G_M66]);
  // R6
  pci_halt_chk: assert property (@(negedge clk_in[G_PCI]) disable iff (!rst_n)
    (ps_cnt >= 3'd3) |-> !clk_out[G_PCI]);
  // R3
  pd_quiet_chk: assert property (@(negedge clk_in[G_PCIF]) disable iff (!rst_n)
    (pd_cnt == 3'd7) |-> ((clk_out & ~ASYNC_SET) == '0));
  // R2
  boot_quiet_chk: assert property (@(negedge clk_in[G_PCIF]) disable iff (!rst_n)
    (boot_cnt < BLAST) |-> (clk_out == '0));
endmodule

bind clk_stop_ctrl clk_stop_ctrl_chk #(.SETTLE_CYC(SETTLE_CYC)) u_chk (
  .rst_n(rst_n), .clk_in(clk_in), .cpu_stop_n(cpu_stop_n), .pci_stop_n(pci_stop_n),
  .pwrdn_n(pwrdn_n), .clk_out(clk_out), .osc_en(osc_en), .vco_en(vco_en)
);

// File: tb/clk_stop_ctrl_tb_top.sv
`timescale 1ns/1ps
module clk_stop_ctrl_tb_top;
  localparam int  SETTLE = 40;
  localparam real TREF   = 28.0;
  localparam real TPCI   = 20.0;

  logic rst_n = 1'b0, cpu_stop_n = 1'b1, pci_stop_n = 1'b1, pwrdn_n = 1'b1;
  logic c_cpu = 1'b1, c_m66 = 1'b1, c_pci = 1'b1, c_mem = 1'b1;
  logic c_apic = 1'b1, c_ref = 1'b1, c_usb = 1'b1;
  logic [7:0] clk_in, clk_out;
  logic osc_en, vco_en;

  assign clk_in = {c_usb, c_ref, c_apic, c_mem, c_pci, c_pci, c_m66, c_cpu};

  always #2.5 c_cpu  = ~c_cpu;
  always #5   c_m66  = ~c_m66;
  always #10  c_pci  = ~c_pci;
  always #5   c_mem  = ~c_mem;
  always #40  c_apic = ~c_apic;
  always #14  c_ref  = ~c_ref;
  always #7   c_usb  = ~c_usb;

  clk_stop_ctrl #(.SETTLE_CYC(SETTLE)) dut_i (
    .rst_n(rst_n), .clk_in(clk_in), .cpu_stop_n(cpu_stop_n), .pci_stop_n(pci_stop_n),
    .pwrdn_n(pwrdn_n), .clk_out(clk_out), .osc_en(osc_en), .vco_en(vco_en)
  );

  int  n_chk = 0, n_bad = 0;
  real half_ns [8] = '{2.5, 5.0, 10.0, 10.0, 5.0, 40.0, 14.0, 7.0};
  int  rises [8] = '{default: 0};
  int  glitch [8] = '{default: 0};
  int  snap [8];
  real last_rise [8] = '{default: 0.0};
  real first_rise [8] = '{default: 0.0};
  real arm_t = 0.0;
  logic [7:0] prev_o = 8'h00;

  always @(clk_out) begin
    for (int i = 0; i < 8; i++) begin
      if (clk_out[i] === 1'b1 && prev_o[i] !== 1'b1) begin
        rises[i]++;
        last_rise[i] = $realtime;
        if (first_rise[i] <= arm_t) first_rise[i] = $realtime;
      end else if (clk_out[i] === 1'b0 && prev_o[i] === 1'b1) begin
        if (($realtime - last_rise[i]) > half_ns[i] + 0.01 ||
            ($realtime - last_rise[i]) < half_ns[i] - 0.01) glitch[i]++;
      end
    end
    prev_o = clk_out;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input real act, input real exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0.3f expected %0.3f", req, what, act, exp);
    end
  endtask

  task automatic take_snap();
    for (int i = 0; i < 8; i++) snap[i] = rises[i];
  endtask

  function automatic int delta(input int i);
    return rises[i] - snap[i];
  endfunction

  task automatic wait_until(input real t);
    if (t > $realtime) #(t - $realtime);
  endtask

  task automatic align(output real p0);
    @(posedge c_pci);
    p0 = $realtime;
    #1;
  endtask

  task automatic t_reset();
    #50;
    chk(clk_out == 8'h00, "R1", "outputs in reset", real'(clk_out), 0.0);
    chk(osc_en == 1'b0, "R1", "osc_en in reset", real'(osc_en), 0.0);
    chk(vco_en == 1'b0, "R1", "vco_en in reset", real'(vco_en), 0.0);
  endtask

  task automatic t_wake(input real tr, input logic [7:0] exp_run);
    int tot;
    wait_until(tr + SETTLE * TREF - 5.0);
    tot = 0;
    for (int i = 0; i < 8; i++) tot += delta(i);
    chk(tot == 0, "R2", "rises before settle", real'(tot), 0.0);
    wait_until(tr + (SETTLE + 3) * TREF + 120.0);
    chk(first_rise[3] >= tr + SETTLE * TREF &&
        first_rise[3] <= tr + (SETTLE + 3) * TREF + 100.0,
        "R2", "first free PCI edge time", first_rise[3] - tr, SETTLE * TREF);
    chk(osc_en && vco_en, "R4", "enables after restart", real'({osc_en, vco_en}), 3.0);
    take_snap();
    #(20 * TPCI);
    for (int i = 0; i < 8; i++) begin
      if (exp_run[i]) chk(delta(i) > 0, "R2", $sformatf("group %0d running", i), real'(delta(i)), 1.0);
      else            chk(delta(i) == 0, "R9", $sformatf("group %0d held by stop", i), real'(delta(i)), 0.0);
    end
  endtask

  task automatic t_pci_stop();
    real p0;
    align(p0);
    pci_stop_n = 1'b0;
    #(10 * TPCI);
    chk(last_rise[2] == p0 + 20.0, "R7", "PCI last edge", last_rise[2] - p0, 20.0);
    take_snap();
    #(8 * TPCI);
    chk(delta(2) == 0, "R6", "stoppable PCI quiet", real'(delta(2)), 0.0);
    chk(delta(3) == 8, "R6", "free PCI edges", real'(delta(3)), 8.0);
    chk(delta(0) > 0 && delta(4) > 0 && delta(7) > 0, "R6", "other groups run",
        real'(delta(0)), 1.0);
    align(p0);
    arm_t = $realtime;
    pci_stop_n = 1'b1;
    #(5 * TPCI);
    chk(first_rise[2] == p0 + 40.0, "R7", "PCI first edge", first_rise[2] - p0, 40.0);
  endtask

  task automatic t_cpu_stop();
    real p0;
    align(p0);
    cpu_stop_n = 1'b0;
    #(6 * TPCI);
    chk(last_rise[0] == p0 + 20.0, "R7", "CPU last edge", last_rise[0] - p0, 20.0);
    chk(last_rise[1] == p0 + 20.0, "R7", "66 MHz last edge", last_rise[1] - p0, 20.0);
    take_snap();
    #(8 * TPCI);
    chk(delta(0) == 0 && delta(1) == 0, "R5", "CPU and 66 MHz quiet",
        real'(delta(0) + delta(1)), 0.0);
    for (int i = 2; i < 8; i++)
      chk(delta(i) > 0, "R5", $sformatf("group %0d unaffected", i), real'(delta(i)), 1.0);
    align(p0);
    arm_t = $realtime;
    cpu_stop_n = 1'b1;
    #(4 * TPCI);
    chk(first_rise[0] == p0 + 25.0, "R7", "CPU first edge", first_rise[0] - p0, 25.0);
    chk(first_rise[1] == p0 + 30.0, "R7", "66 MHz first edge", first_rise[1] - p0, 30.0);
  endtask

  task automatic t_both_stop();
    #3;
    cpu_stop_n = 1'b0;
    pci_stop_n = 1'b0;
    #(6 * TPCI);
    take_snap();
    #(10 * TPCI);
    chk(delta(0) + delta(1) + delta(2) == 0, "R5", "stopped groups with both stops",
        real'(delta(0) + delta(1) + delta(2)), 0.0);
    for (int i = 3; i < 8; i++)
      chk(delta(i) > 0, "R6", $sformatf("group %0d with both stops", i), real'(delta(i)), 1.0);
    cpu_stop_n = 1'b1;
    pci_stop_n = 1'b1;
    #(6 * TPCI);
  endtask

  task automatic t_power();
    real p0, tr;
    int tot;
    align(p0);
    take_snap();
    pwrdn_n = 1'b0;
    #(8 * TPCI);
    chk(delta(3) <= 2, "R3", "free PCI edges after power down", real'(delta(3)), 2.0);
    chk(osc_en == 1'b0 && vco_en == 1'b0, "R4", "enables dropped",
        real'({osc_en, vco_en}), 0.0);
    chk(clk_out == 8'h00, "R3", "outputs low in power down", real'(clk_out), 0.0);
    take_snap();
    cpu_stop_n = 1'b0;
    pci_stop_n = 1'b0;
    #(4 * TPCI);
    cpu_stop_n = 1'b1;
    pci_stop_n = 1'b1;
    #(6 * TPCI);
    tot = 0;
    for (int i = 0; i < 8; i++) tot += delta(i);
    chk(tot == 0 && clk_out == 8'h00, "R9", "stops toggled in power down", real'(tot), 0.0);
    #3;
    cpu_stop_n = 1'b0;
    take_snap();
    tr = $realtime;
    arm_t = tr;
    pwrdn_n = 1'b1;
    @(posedge osc_en);
    #1;
    chk(vco_en == 1'b0, "R4", "VCO after oscillator", real'(vco_en), 0.0);
    t_wake(tr, 8'b1111_1100);
    #3;
    take_snap();
    cpu_stop_n = 1'b1;
    #(10 * TPCI);
    chk(delta(0) > 0 && delta(1) > 0, "R9", "CPU groups after stop release",
        real'(delta(0)), 1.0);
  endtask

  task automatic t_glitch();
    for (int i = 0; i < 8; i++)
      chk(glitch[i] == 0, "R8", $sformatf("pulse width group %0d", i), real'(glitch[i]), 0.0);
  endtask

  initial begin
    t_reset();
    #51;
    take_snap();
    arm_t = $realtime;
    rst_n = 1'b1;
    t_wake($realtime, 8'hFF);
    t_pci_stop();
    t_cpu_stop();
    t_both_stop();
    t_power();
    t_glitch();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #2_000_000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule